// File: doc/BRIEF.md
# Memory Protection Region Configuration Bank

This block holds the configuration state of an eight-region memory protection unit. Software reaches it through a small word-addressed register port. Four registers are visible: a global control word, a region selector, and a base and an attribute window. The base and attribute windows always refer to the region named by the selector. Every access must be privileged. An unprivileged access changes nothing, reads back zero, and raises an error strobe in the same cycle.

Each region keeps a base address, a 5-bit size code and an enable bit. The region spans 2^(size+1) bytes. The base the block presents, both on readback and on its outputs, is cleared below the region's alignment boundary. Size code 31 means the full 4 GB map, so the base is zero. A write to the base window with its redirect bit set first moves the selector to the region carried in that same write, then stores the base there. An optional comparator flags every enabled region that contains a probe address, while the global enable is on.

Top module: `mpu_region_cfg`

## Requirements
- R1: After reset, every register reads 0, the global enable is 0, and all per-region base, size, enable and hit outputs are 0.
- R2: Offset 0x0 is the control word. Bit 0 is the global enable and reads back as written. Bits 31:1 read 0.
- R3: Offset 0x4 is the selector. Bits 2:0 pick one of eight regions. Bits 31:3 read 0 and ignore writes.
- R4: Offset 0x8 (base) and offset 0xC (attribute) read and write only the region held in the selector. The attribute word has bit 0 as the region enable and bits 5:1 as the size code. All other attribute bits read 0.
- R5: A base write with bit 4 set loads wdata[2:0] into the selector and stores the base into that region. Bit 4 always reads 0.
- R6: A base readback returns the aligned base in bits 31:5 and the current selector in bits 2:0. Bits below N = size+1 are cleared (bits 4:0 always). For a size code below 4, bits 31:5 are kept. The region_base output carries the same aligned base with bits 4:0 zero.
- R7: With size code 31, the region's base reads 0 and the region contains every address.
- R8: With acc_priv low, a write changes no state, a read returns 0, and acc_err is 1 in the same cycle as the access. acc_err is 0 for any other access.
- R9: Region i's hit flag is 1 exactly when the region is enabled, its size code is at least 4, and the probe address equals the aligned base under the region's size mask. A size code below 4 never hits.
- R10: While the global enable is 0, all hit flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | Access comes from privileged mode |
| acc_addr | input | 4 | Byte offset of the register (bits 3:2 decode) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational in the access cycle |
| acc_err | output | 1 | Rejected (unprivileged) access strobe |
| mpu_on | output | 1 | Global enable |
| region_base | output | 256 | Aligned base per region, region i at bits 32i+31:32i |
| region_size | output | 40 | Size code per region, region i at bits 5i+4:5i |
| region_en | output | 8 | Enable per region |
| probe_addr | input | 32 | Address checked against all regions |
| region_hit | output | 8 | Per-region hit flags |

## Verification
Random privileged and unprivileged traffic covers all four offsets, with random data that often carries the redirect bit. This traffic separates selector-relative access from a fixed region index, and a redirected base write from a plain one. Directed cases cover sizes below 4, a 32-byte region, a 64 KB region and the 4 GB code. These tell correct alignment masking from off-by-one boundaries. Probe addresses are placed inside, just past the end of, and below each region's span. That placement distinguishes a correct size mask from one that is too wide or too narrow, and it shows the gating by both the region and the global enables.

// File: rtl/mpu_cfg_pkg.sv
package mpu_cfg_pkg;

    localparam int ADDR_W   = 32;
    localparam int SIZE_W   = 5;
    localparam int BASE_LSB = 5;
    localparam int MIN_SIZE = 4;
    localparam int FULL_MAP = 31;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_SEL  = 2'd1,
        REG_BASE = 2'd2,
        REG_ATTR = 2'd3
    } reg_idx_e;

    localparam int REDIRECT_BIT = 4;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              en;
    } attr_t;

    function automatic logic [ADDR_W-1:0] align_mask(input logic [SIZE_W-1:0] sz);
        logic [ADDR_W-1:0] m;
        if (sz == SIZE_W'(FULL_MAP))
            m = '0;
        else if (sz < SIZE_W'(MIN_SIZE))
            m = ~ADDR_W'((1 << BASE_LSB) - 1);
        else
            m = ~((ADDR_W'(1) << ({27'd0, sz} + 32'd1)) - ADDR_W'(1));
        return m;
    endfunction

endpackage

// File: rtl/mpu_region_slot.sv
module mpu_region_slot
    import mpu_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_base,
    input  logic              wr_attr,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base_o,
    output attr_t             attr_o
);

    logic [ADDR_W-1:BASE_LSB] raw_q;
    attr_t                    attr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            attr_q <= '0;
        end else begin
            if (wr_base)
                raw_q <= wdata[ADDR_W-1:BASE_LSB];
            if (wr_attr)
                attr_q <= attr_t'(wdata[SIZE_W:0]);
        end
    end

    always_comb begin
        base_o = {raw_q, {BASE_LSB{1'b0}}} & align_mask(attr_q.size);
        attr_o = attr_q;
    end

    // R4: region state moves only on a write aimed at this slot
    a_r4_slot_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_base && !wr_attr |=> $stable(raw_q) && $stable(attr_q));

    // R7: full-map size forces a zero base
    a_r7_full_zero: assert property (@(posedge clk) disable iff (rst)
        attr_o.size == SIZE_W'(FULL_MAP) |-> base_o == '0);

endmodule

// File: rtl/mpu_hit_cmp.sv
module mpu_hit_cmp
    import mpu_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              glob_en,
    input  logic [ADDR_W-1:0] probe,
    input  logic [ADDR_W-1:0] base,
    input  attr_t             attr,
    output logic              hit
);

    logic size_ok;
    logic match;

    always_comb begin
        size_ok = attr.size >= SIZE_W'(MIN_SIZE);
        match   = (probe & align_mask(attr.size)) == base;
        hit     = glob_en && attr.en && size_ok && match;
    end

    // R9: undersized regions never report a hit
    a_r9_small_never: assert property (@(posedge clk) disable iff (rst)
        attr.size < SIZE_W'(MIN_SIZE) |-> !hit);

endmodule

// File: rtl/mpu_region_cfg.sv
module mpu_region_cfg
    import mpu_cfg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int OFS_W       = 4,
    parameter bit HIT_CHECK   = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          acc_valid,
    input  logic                          acc_write,
    input  logic                          acc_priv,
    input  logic [OFS_W-1:0]              acc_addr,
    input  logic [ADDR_W-1:0]             acc_wdata,
    output logic [ADDR_W-1:0]             acc_rdata,
    output logic                          acc_err,
    output logic                          mpu_on,
    output logic [NUM_REGIONS*ADDR_W-1:0] region_base,
    output logic [NUM_REGIONS*SIZE_W-1:0] region_size,
    output logic [NUM_REGIONS-1:0]        region_en,
    input  logic [ADDR_W-1:0]             probe_addr,
    output logic [NUM_REGIONS-1:0]        region_hit
);

    localparam int SEL_W = $clog2(NUM_REGIONS);

    logic                   on_q;
    logic [SEL_W-1:0]       sel_q;
    logic [SEL_W-1:0]       target;
    reg_idx_e               idx;
    logic                   ok_acc;
    logic                   ok_wr;
    logic                   redirect;
    logic [NUM_REGIONS-1:0] wr_base_v;
    logic [NUM_REGIONS-1:0] wr_attr_v;
    logic [ADDR_W-1:0]      base_v [NUM_REGIONS];
    attr_t                  attr_v [NUM_REGIONS];

    always_comb begin
        idx      = reg_idx_e'(acc_addr[3:2]);
        ok_acc   = acc_valid && acc_priv;
        ok_wr    = ok_acc && acc_write;
        acc_err  = acc_valid && !acc_priv;
        redirect = ok_wr && idx == REG_BASE && acc_wdata[REDIRECT_BIT];
        target   = redirect ? acc_wdata[SEL_W-1:0] : sel_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= 1'b0;
            sel_q <= '0;
        end else begin
            if (ok_wr && idx == REG_CTRL)
                on_q <= acc_wdata[0];
            if (ok_wr && idx == REG_SEL)
                sel_q <= acc_wdata[SEL_W-1:0];
            else if (redirect)
                sel_q <= acc_wdata[SEL_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        always_comb begin
            wr_base_v[i] = ok_wr && idx == REG_BASE && target == SEL_W'(i);
            wr_attr_v[i] = ok_wr && idx == REG_ATTR && sel_q == SEL_W'(i);
        end

        mpu_region_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_base (wr_base_v[i]),
            .wr_attr (wr_attr_v[i]),
            .wdata   (acc_wdata),
            .base_o  (base_v[i]),
            .attr_o  (attr_v[i])
        );

        assign region_base[i*ADDR_W +: ADDR_W] = base_v[i];
        assign region_size[i*SIZE_W +: SIZE_W] = attr_v[i].size;
        assign region_en[i]                    = attr_v[i].en;

        if (HIT_CHECK) begin : g_hit
            mpu_hit_cmp u_cmp (
                .clk     (clk),
                .rst     (rst),
                .glob_en (on_q),
                .probe   (probe_addr),
                .base    (base_v[i]),
                .attr    (attr_v[i]),
                .hit     (region_hit[i])
            );
        end else begin : g_nohit
            assign region_hit[i] = 1'b0;
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (ok_acc && !acc_write) begin
            unique case (idx)
                REG_CTRL: acc_rdata[0] = on_q;
                REG_SEL:  acc_rdata[SEL_W-1:0] = sel_q;
                REG_BASE: begin
                    acc_rdata = base_v[sel_q];
                    acc_rdata[SEL_W-1:0] = sel_q;
                end
                REG_ATTR: acc_rdata[SIZE_W:0] = attr_v[sel_q];
                default:  acc_rdata = '0;
            endcase
        end
    end

    assign mpu_on = on_q;

    // R8: a rejected access strobes the error and reads zero
    a_r8_unpriv_err: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_priv |-> acc_err && acc_rdata == '0);

    // R8: a rejected write leaves control and selector untouched
    a_r8_no_write: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_write && !acc_priv |=> $stable(on_q) && $stable(sel_q));

    // R5: redirected base write moves the selector
    a_r5_redirect: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_priv && acc_write && acc_addr[3:2] == 2'd2 && acc_wdata[REDIRECT_BIT]
        |=> sel_q == $past(acc_wdata[SEL_W-1:0]));

    // R3: selector changes only through the selector or a redirect
    a_r3_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_priv && acc_write) |=> $stable(sel_q));

    // R10: no hits while globally disabled
    a_r10_hit_gated: assert property (@(posedge clk) disable iff (rst)
        !mpu_on |-> region_hit == '0);

endmodule

// File: tb/mpu_region_cfg_bench.sv
module mpu_region_cfg_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         acc_valid, acc_write, acc_priv;
    logic [3:0]   acc_addr;
    logic [31:0]  acc_wdata;
    logic [31:0]  acc_rdata;
    logic         acc_err;
    logic         mpu_on;
    logic [255:0] region_base;
    logic [39:0]  region_size;
    logic [7:0]   region_en;
    logic [31:0]  probe_addr;
    logic [7:0]   region_hit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_raw [8];
    logic [4:0]  m_size [8];
    logic        m_en [8];
    logic        m_on;
    logic [2:0]  m_sel;

    always #2 clk = ~clk;

    mpu_region_cfg u_mpu_region_cfg (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_priv(acc_priv), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .mpu_on(mpu_on),
        .region_base(region_base), .region_size(region_size), .region_en(region_en),
        .probe_addr(probe_addr), .region_hit(region_hit)
    );

    function automatic logic [31:0] f_mask(input logic [4:0] sz);
        if (sz == 5'd31) return 32'h0;
        if (sz < 5'd4) return 32'hFFFF_FFE0;
        return ~((32'd1 << (sz + 5'd1)) - 32'd1);
    endfunction

    function automatic logic [31:0] f_base(input int r);
        return m_raw[r] & f_mask(m_size[r]);
    endfunction

    function automatic logic [7:0] f_hits(input logic [31:0] p);
        logic [7:0] h = '0;
        for (int r = 0; r < 8; r++)
            h[r] = m_on && m_en[r] && m_size[r] >= 5'd4 &&
                   ((p & f_mask(m_size[r])) == f_base(r));
        return h;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        case (a[3:2])
            2'd0: m_on = d[0];
            2'd1: m_sel = d[2:0];
            2'd2: begin
                if (d[4]) m_sel = d[2:0];
                m_raw[m_sel] = {d[31:5], 5'd0};
            end
            default: begin
                m_en[m_sel]   = d[0];
                m_size[m_sel] = d[5:1];
            end
        endcase
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a[3:2])
            2'd0: return {31'd0, m_on};
            2'd1: return {29'd0, m_sel};
            2'd2: return f_base(m_sel) | {29'd0, m_sel};
            default: return {26'd0, m_size[m_sel], m_en[m_sel]};
        endcase
    endfunction

    task automatic acc(input bit wr, input bit priv, input logic [3:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_priv = priv; acc_addr = a; acc_wdata = d;
        #1;
        chk({req, "/err"}, {31'd0, acc_err}, {31'd0, !priv});
        if (!wr) chk(req, acc_rdata, priv ? model_read(a) : 32'h0);
        @(posedge clk);
        if (wr && priv) model_write(a, d);
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic check_outputs(input string req);
        @(negedge clk);
        #1;
        for (int r = 0; r < 8; r++) begin
            chk({req, "/base"}, region_base[r*32 +: 32], f_base(r));
            chk({req, "/size"}, {27'd0, region_size[r*5 +: 5]}, {27'd0, m_size[r]});
        end
        chk({req, "/on"}, {31'd0, mpu_on}, {31'd0, m_on});
    endtask

    task automatic probe(input logic [31:0] p, input string req);
        @(negedge clk);
        probe_addr = p;
        #1;
        chk(req, {24'd0, region_hit}, {24'd0, f_hits(p)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0; acc_priv = 1'b0;
        acc_addr = '0; acc_wdata = '0; probe_addr = '0;
        m_on = 1'b0; m_sel = '0;
        for (int r = 0; r < 8; r++) begin m_raw[r] = '0; m_size[r] = '0; m_en[r] = 1'b0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check_outputs("R1");
        chk("R1/en", {24'd0, region_en}, 32'h0);
        for (int a = 0; a < 4; a++) acc(1'b0, 1'b1, 4'(a*4), 32'h0, "R1");
        probe(32'h0, "R1/hit");

        // R2 control bits
        acc(1'b1, 1'b1, 4'h0, 32'hFFFF_FFFF, "R2");
        acc(1'b0, 1'b1, 4'h0, 32'h0, "R2");
        // R3 selector upper bits
        acc(1'b1, 1'b1, 4'h4, 32'hFFFF_FFFD, "R3");
        acc(1'b0, 1'b1, 4'h4, 32'h0, "R3");
        // R4 attribute on selected region, extra bits dropped
        acc(1'b1, 1'b1, 4'hC, 32'hFFFF_FF9F, "R4");
        acc(1'b0, 1'b1, 4'hC, 32'h0, "R4");
        // R5 redirect plus base write, then readback of bit 4 and selector
        acc(1'b1, 1'b1, 4'h8, 32'h1234_5617, "R5");
        acc(1'b0, 1'b1, 4'h4, 32'h0, "R5");
        acc(1'b0, 1'b1, 4'h8, 32'h0, "R5");
        // R6 64 KB region (size 15) in region 7
        acc(1'b1, 1'b1, 4'hC, {26'd0, 5'd15, 1'b1}, "R6");
        acc(1'b0, 1'b1, 4'h8, 32'h0, "R6");
        check_outputs("R6");
        probe(32'h1234_FFFF, "R9");
        probe(32'h1235_0000, "R9");
        probe(32'h1233_FFFF, "R9");
        // R6 32-byte region (size 4) and undersized (size 3)
        acc(1'b1, 1'b1, 4'h8, 32'h0000_1234 | 32'h10, "R6");
        acc(1'b1, 1'b1, 4'hC, {26'd0, 5'd4, 1'b1}, "R6");
        acc(1'b0, 1'b1, 4'h8, 32'h0, "R6");
        probe(32'h0000_1220, "R9");
        probe(32'h0000_1240, "R9");
        acc(1'b1, 1'b1, 4'hC, {26'd0, 5'd3, 1'b1}, "R9");
        acc(1'b0, 1'b1, 4'h8, 32'h0, "R6");
        probe(32'h0000_1220, "R9");
        // R7 full map on region 2
        acc(1'b1, 1'b1, 4'h8, 32'hDEAD_BE12, "R7");
        acc(1'b1, 1'b1, 4'hC, {26'd0, 5'd31, 1'b1}, "R7");
        acc(1'b0, 1'b1, 4'h8, 32'h0, "R7");
        probe(32'h8765_4321, "R7");
        probe(32'hFFFF_FFFF, "R7");
        // R10 global disable
        acc(1'b1, 1'b1, 4'h0, 32'h0, "R10");
        probe(32'h8765_4321, "R10");
        acc(1'b1, 1'b1, 4'h0, 32'h1, "R10");
        // R8 unprivileged accesses
        acc(1'b1, 1'b0, 4'h0, 32'h0, "R8");
        acc(1'b1, 1'b0, 4'h8, 32'hAAAA_AA15, "R8");
        acc(1'b1, 1'b0, 4'hC, 32'h0, "R8");
        acc(1'b0, 1'b0, 4'h4, 32'h0, "R8");
        acc(1'b0, 1'b1, 4'h4, 32'h0, "R8");
        acc(1'b0, 1'b1, 4'hC, 32'h0, "R8");
        check_outputs("R8");

        // random mixed traffic
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] d = $urandom;
            logic [3:0]  a = 4'($urandom_range(0, 3) * 4);
            bit          p = ($urandom_range(0, 7) != 0);
            bit          w = $urandom_range(0, 1);
            if (a == 4'hC && $urandom_range(0, 1)) d[5:1] = 5'($urandom_range(3, 20));
            acc(w, p, a, d, "R4");
            if (n % 25 == 0) check_outputs("R6");
            if (n % 5 == 0) begin
                int r = $urandom_range(0, 7);
                logic [31:0] off = $urandom;
                logic [31:0] pa = f_base(r) | (off & ~f_mask(m_size[r]));
                probe($urandom_range(0, 3) == 0 ? 32'($urandom) : pa, "R9");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule